// File: doc/BRIEF.md
# Eight-Bit Timer with Shared Prescaler

This block is an 8-bit up-counter that advances on one of two sources: a one-cycle enable that marks each instruction cycle, or edges on an external input that is already synchronized to the system clock. The polarity of the edge it counts can be chosen. A single prescaler sits between the chosen source and the counter. It can instead be lent to a neighbouring watchdog, which then receives the divided tick. While the prescaler is lent out, the timer counts every source event at a 1:1 rate.

Software loads the counter through a write strobe and reads it back on a plain output. When the counter passes from 255 to 0, it sets a sticky overflow flag. This happens whatever the enables hold, and the flag stays set until a clear strobe arrives. An interrupt request combines that flag with a local enable and a global enable. Every pin is a plain control or status signal. No stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `tmr8_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the following hold: `cnt_q` is 0, `ovf_flag` is 0, `irq` is 0, and the prescaler count is 0.
- R2: With `cfg_src`=0, the source event is `cyc_en`. With `cfg_assign`=1 (prescaler lent to the watchdog), every cycle in which `cyc_en` is high adds one to `cnt_q`, visible after that clock edge.
- R3: With `cfg_src`=1, the source event is an edge on `ext_pin`. The edge is found by comparing the pin with its sample from the previous clock. `cfg_edge`=0 counts low-to-high changes and `cfg_edge`=1 counts high-to-low changes. Changes of the other polarity have no effect, and neither does `cyc_en`.
- R4: With `cfg_assign`=0, the prescaler is a free-running 8-bit count of source events. The timer advances on the events where the low `cfg_rate`+1 bits of that count are all ones, so codes 0 to 7 give 1:2 to 1:256.
- R5: With `cfg_assign`=1, the prescaler counts `wdt_base` pulses. `wdt_tick` pulses on the pulses where the low `cfg_rate` bits of the count are all ones, so codes 0 to 7 give 1:1 to 1:128. With `cfg_assign`=0, `wdt_tick` follows `wdt_base` directly.
- R6: `wr_en` loads `wr_data` into the counter on that clock edge, and an increment in the same cycle is dropped. With `cfg_assign`=0, the same write also clears the prescaler count.
- R7: An increment from 255 wraps the counter to 0 and sets `ovf_flag`, whatever `ovf_ie` and `glob_ie` hold. The flag stays set until a cycle with `flag_clr` high and no new overflow. If an overflow and a clear arrive in the same cycle, the flag is set.
- R8: `irq` is high exactly when `ovf_flag`, `ovf_ie` and `glob_ie` are all high, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, one pulse per cycle to count |
| ext_pin | input | 1 | Synchronized external count input |
| wdt_base | input | 1 | Base tick of the watchdog |
| cfg_src | input | 1 | 1: count external edges, 0: count cyc_en |
| cfg_edge | input | 1 | 1: falling edges, 0: rising edges |
| cfg_assign | input | 1 | 1: prescaler lent to watchdog, 0: prescaler on timer |
| cfg_rate | input | 3 | Prescaler ratio code |
| wr_en | input | 1 | Load strobe for the counter |
| wr_data | input | 8 | Value to load |
| flag_clr | input | 1 | Clears the overflow flag |
| ovf_ie | input | 1 | Timer interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| cnt_q | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| wdt_tick | output | 1 | Tick delivered to the watchdog |

## Verification
The bench builds the block with its default widths: an 8-bit counter and an 8-bit prescaler. With these widths the largest ratio, 1:256, and a counter wrap are both reachable within a few hundred cycles, especially when the counter is preloaded close to 255. A behavioural model mirrors the prescaler with integer arithmetic. This lets the bench change the rate, the owner and the edge polarity in the middle of a run and still predict every cycle. That covers handing the prescaler from one owner to the other, and writes that do or do not clear it.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  // Which consumer the prescaler serves.
  typedef enum logic {
    PS_TO_TIMER = 1'b0,
    PS_TO_WDOG  = 1'b1
  } ps_owner_e;
endpackage

// File: rtl/tmr8_evt_src.sv
// Selects the counting source and detects pin edges against the previous sample.
module tmr8_evt_src (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic ext_pin,
  input  logic src_ext,
  input  logic edge_fall,
  output logic evt
);
  logic pin_prev;
  logic rise_hit;
  logic fall_hit;
  logic edge_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_prev <= 1'b0;
    else        pin_prev <= ext_pin;
  end

  assign rise_hit = ext_pin & ~pin_prev;
  assign fall_hit = ~ext_pin & pin_prev;
  assign edge_hit = edge_fall ? fall_hit : rise_hit;
  assign evt      = src_ext ? edge_hit : cyc_en;
endmodule

// File: rtl/tmr8_prescale.sv
// Free-running event count; a tick fires when the selected low bits are all ones.
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int PS_W = 8,
  localparam int RATE_W = $clog2(PS_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              clr,
  input  ps_owner_e         owner,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [PS_W-1:0]  pcnt;
  logic [PS_W-1:0]  mask;
  logic [RATE_W:0]  eff;

  // The timer always divides by at least two; the watchdog may pass 1:1.
  assign eff = {1'b0, rate} + {{RATE_W{1'b0}}, (owner == PS_TO_TIMER)};

  for (genvar g = 0; g < PS_W; g++) begin : g_mask
    assign mask[g] = (eff > (RATE_W+1)'(g));
  end

  assign tick = evt && ((pcnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)   pcnt <= '0;
    else if (clr) pcnt <= '0;
    else if (evt) pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr8_count.sv
// Loadable up-counter with wrap indication.
module tmr8_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign wrap = inc && !wr_en && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr8_flag.sv
// Sticky overflow flag; a set wins over a clear in the same cycle.
module tmr8_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ie,
  input  logic gie,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag & ie & gie;
endmodule

// File: rtl/tmr8_core.sv
// Top: routes source events and the shared prescaler to timer or watchdog.
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PS_W  = 8,
  localparam int RATE_W = $clog2(PS_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              ext_pin,
  input  logic              wdt_base,
  input  logic              cfg_src,
  input  logic              cfg_edge,
  input  logic              cfg_assign,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              flag_clr,
  input  logic              ovf_ie,
  input  logic              glob_ie,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_flag,
  output logic              irq,
  output logic              wdt_tick
);
  ps_owner_e owner;
  logic      src_evt;
  logic      ps_evt;
  logic      ps_clr;
  logic      ps_tick;
  logic      tmr_inc;
  logic      wrap;

  assign owner = ps_owner_e'(cfg_assign);

  tmr8_evt_src u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_en    (cyc_en),
    .ext_pin   (ext_pin),
    .src_ext   (cfg_src),
    .edge_fall (cfg_edge),
    .evt       (src_evt)
  );

  assign ps_evt = (owner == PS_TO_WDOG) ? wdt_base : src_evt;
  assign ps_clr = wr_en && (owner == PS_TO_TIMER);

  tmr8_prescale #(.PS_W(PS_W)) u_ps (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (ps_evt),
    .clr   (ps_clr),
    .owner (owner),
    .rate  (cfg_rate),
    .tick  (ps_tick)
  );

  assign tmr_inc  = (owner == PS_TO_WDOG) ? src_evt : ps_tick;
  assign wdt_tick = (owner == PS_TO_WDOG) ? ps_tick : wdt_base;

  tmr8_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (tmr_inc),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cnt_q   (cnt_q),
    .wrap    (wrap)
  );

  tmr8_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wrap),
    .clr   (flag_clr),
    .ie    (ovf_ie),
    .gie   (glob_ie),
    .flag  (ovf_flag),
    .irq   (irq)
  );
endmodule

// File: rtl/tmr8_core_chk.sv
module tmr8_core_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_en,
  input logic             ext_pin,
  input logic             cfg_src,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             flag_clr,
  input logic             ovf_ie,
  input logic             glob_ie,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_flag,
  input logic             irq,
  input logic             wdt_base,
  input logic             wdt_tick
);
  localparam logic [CNT_W-1:0] TOP = '1;

  p_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (cnt_q == '0 && !ovf_flag && !irq));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_src && !cyc_en && !wr_en) |=> $stable(cnt_q));

  p_pin_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_src && $stable(ext_pin) && !wr_en) |=> $stable(cnt_q));

  p_wdt_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tick |-> wdt_base);

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_data)));

  p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == TOP && cnt_q == '0 && !$past(wr_en)) |-> ovf_flag);

  p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_flag);

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_ie || !glob_ie) |-> !irq);
endmodule

bind tmr8_core tmr8_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cyc_en   (cyc_en),
  .ext_pin  (ext_pin),
  .cfg_src  (cfg_src),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .flag_clr (flag_clr),
  .ovf_ie   (ovf_ie),
  .glob_ie  (glob_ie),
  .cnt_q    (cnt_q),
  .ovf_flag (ovf_flag),
  .irq      (irq),
  .wdt_base (wdt_base),
  .wdt_tick (wdt_tick)
);

// File: tb/sim_tmr8_core.sv
module sim_tmr8_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, ext_pin = 1'b0, wdt_base = 1'b0;
  logic       cfg_src = 1'b0, cfg_edge = 1'b0, cfg_assign = 1'b0;
  logic [2:0] cfg_rate = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       flag_clr = 1'b0, ovf_ie = 1'b0, glob_ie = 1'b0;
  logic [7:0] cnt_q;
  logic       ovf_flag, irq, wdt_tick;

  int    checks = 0;
  int    errors = 0;
  int    tick_seen = 0;
  string req = "R1";

  int m_cnt = 0;
  int m_pcnt = 0;
  bit m_flag = 0;
  bit m_prev = 0;

  always #4 clk = ~clk;

  tmr8_core u0 (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .wdt_base(wdt_base), .cfg_src(cfg_src), .cfg_edge(cfg_edge),
    .cfg_assign(cfg_assign), .cfg_rate(cfg_rate), .wr_en(wr_en),
    .wr_data(wr_data), .flag_clr(flag_clr), .ovf_ie(ovf_ie),
    .glob_ie(glob_ie), .cnt_q(cnt_q), .ovf_flag(ovf_flag), .irq(irq),
    .wdt_tick(wdt_tick)
  );

  // Reference model, written from the requirements.
  function automatic bit f_src_evt();
    if (cfg_src)
      return cfg_edge ? (!ext_pin && m_prev) : (ext_pin && !m_prev);
    return cyc_en;
  endfunction

  function automatic int f_ratio();
    return cfg_assign ? (1 << cfg_rate) : (2 << cfg_rate);
  endfunction

  function automatic bit f_ptick();
    bit pe;
    pe = cfg_assign ? wdt_base : f_src_evt();
    return pe && ((m_pcnt % f_ratio()) == f_ratio() - 1);
  endfunction

  always @(posedge clk) begin
    bit se, pe, pt, inc, setf;
    if (!rst_n) begin
      m_cnt = 0; m_pcnt = 0; m_flag = 0; m_prev = 0;
    end else begin
      se = f_src_evt();
      pe = cfg_assign ? wdt_base : se;
      pt = f_ptick();
      inc = cfg_assign ? se : pt;
      setf = 0;
      if (wr_en) begin
        m_cnt = wr_data;
        if (!cfg_assign) m_pcnt = 0;
        else if (pe) m_pcnt = (m_pcnt + 1) % 256;
      end else begin
        if (pe) m_pcnt = (m_pcnt + 1) % 256;
        if (inc) begin
          if (m_cnt == 255) begin m_cnt = 0; setf = 1; end
          else m_cnt = m_cnt + 1;
        end
      end
      if (setf) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_prev = ext_pin;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(posedge clk) begin
    bit e_irq, e_wdt;
    #2;
    e_irq = m_flag && ovf_ie && glob_ie;
    e_wdt = cfg_assign ? f_ptick() : wdt_base;
    checks++;
    if (cnt_q !== 8'(m_cnt) || ovf_flag !== m_flag || irq !== e_irq || wdt_tick !== e_wdt) begin
      errors++;
      $display("FAIL %s per-cycle: cnt %0d/%0d flag %0d/%0d irq %0d/%0d wdt %0d/%0d (actual/expected)",
               req, cnt_q, m_cnt, ovf_flag, m_flag, irq, e_irq, wdt_tick, e_wdt);
    end
    if (wdt_tick === 1'b1) tick_seen++;
  end

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] v);
    wr_data = v; wr_en = 1'b1; cyc(1); wr_en = 1'b0;
  endtask

  task automatic toggle_pin(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = ~ext_pin; cyc(2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    req = "R1";
    cyc(3);
    chk("R1", "cnt in reset", cnt_q, 0);
    rst_n = 1'b1; cyc(1);
    chk("R1", "cnt after reset", cnt_q, 0);
    chk("R1", "flag after reset", ovf_flag, 0);
    chk("R1", "irq after reset", irq, 0);

    // R2: instruction-cycle source, prescaler with watchdog
    req = "R2";
    cfg_assign = 1'b1; cfg_src = 1'b0;
    cyc_en = 1'b1; cyc(10); cyc_en = 1'b0;
    chk("R2", "10 cycle events", cnt_q, 10);
    for (int i = 0; i < 6; i++) begin
      cyc_en = 1'b1; cyc(1); cyc_en = 1'b0; cyc(1);
    end
    chk("R2", "alternate events", cnt_q, 16);

    // R4: prescaler on timer
    req = "R4";
    cfg_assign = 1'b0; cfg_rate = 3'd0;
    load(8'd0);
    cyc_en = 1'b1; cyc(8); cyc_en = 1'b0;
    chk("R4", "1:2 after 8 events", cnt_q, 4);
    cfg_rate = 3'd2;
    load(8'd0);
    cyc_en = 1'b1; cyc(16); cyc_en = 1'b0;
    chk("R4", "1:8 after 16 events", cnt_q, 2);
    cfg_rate = 3'd7;
    load(8'd0);
    cyc_en = 1'b1; cyc(255); cyc_en = 1'b0;
    chk("R4", "1:256 before tick", cnt_q, 0);
    cyc_en = 1'b1; cyc(1); cyc_en = 1'b0;
    chk("R4", "1:256 at tick", cnt_q, 1);

    // R6: write clears prescaler, write beats increment
    req = "R6";
    cfg_rate = 3'd2;
    load(8'd0);
    cyc_en = 1'b1; cyc(5); cyc_en = 1'b0;
    load(8'd100);
    cyc_en = 1'b1; cyc(7); cyc_en = 1'b0;
    chk("R6", "prescaler cleared by write", cnt_q, 100);
    cyc_en = 1'b1; cyc(1); cyc_en = 1'b0;
    chk("R6", "tick on 8th event", cnt_q, 101);
    cfg_assign = 1'b1;
    cyc_en = 1'b1; wr_data = 8'd50; wr_en = 1'b1; cyc(1);
    wr_en = 1'b0; cyc_en = 1'b0;
    chk("R6", "write wins over increment", cnt_q, 50);

    // R3: external edges
    req = "R3";
    cfg_src = 1'b1; cfg_edge = 1'b0;
    load(8'd0);
    toggle_pin(6);
    chk("R3", "rising edges", cnt_q, 3);
    cfg_edge = 1'b1;
    toggle_pin(6);
    chk("R3", "falling edges", cnt_q, 6);
    cyc_en = 1'b1; cyc(4); cyc_en = 1'b0;
    chk("R3", "cyc_en ignored on pin source", cnt_q, 6);

    // R5: watchdog tick
    req = "R5";
    cfg_src = 1'b0; cfg_edge = 1'b0;
    cfg_assign = 1'b0; load(8'd0);
    cfg_assign = 1'b1; cfg_rate = 3'd3;
    cyc(1);
    tick_seen = 0;
    wdt_base = 1'b1; cyc(32); wdt_base = 1'b0; cyc(1);
    chk("R5", "1:8 watchdog ticks", tick_seen, 4);
    chk("R5", "timer untouched by base", cnt_q, 0);
    cfg_assign = 1'b0;
    tick_seen = 0;
    wdt_base = 1'b1; cyc(5); wdt_base = 1'b0; cyc(1);
    chk("R5", "1:1 pass-through ticks", tick_seen, 5);
    cfg_assign = 1'b1; cfg_rate = 3'd0;
    tick_seen = 0;
    wdt_base = 1'b1; cyc(3); wdt_base = 1'b0; cyc(1);
    chk("R5", "1:1 on watchdog", tick_seen, 3);

    // R7: overflow flag
    req = "R7";
    ovf_ie = 1'b0; glob_ie = 1'b0;
    load(8'hFD);
    cyc_en = 1'b1; cyc(3); cyc_en = 1'b0;
    chk("R7", "wrap value", cnt_q, 0);
    chk("R7", "flag set with enables off", ovf_flag, 1);
    chk("R7", "irq off when masked", irq, 0);
    cyc(3);
    chk("R7", "flag sticky", ovf_flag, 1);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R7", "flag cleared", ovf_flag, 0);
    load(8'hFF);
    cyc_en = 1'b1; flag_clr = 1'b1; cyc(1); cyc_en = 1'b0; flag_clr = 1'b0;
    chk("R7", "set wins over clear", ovf_flag, 1);

    // R8: interrupt gating
    req = "R8";
    ovf_ie = 1'b1; glob_ie = 1'b0; #1;
    chk("R8", "global off", irq, 0);
    cyc(1); glob_ie = 1'b1; #1;
    chk("R8", "both on", irq, 1);
    cyc(1); ovf_ie = 1'b0; #1;
    chk("R8", "local off", irq, 0);
    cyc(1); ovf_ie = 1'b1; flag_clr = 1'b1; cyc(1); flag_clr = 1'b0; #1;
    chk("R8", "flag clear drops irq", irq, 0);
    cyc(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule